// File: doc/BRIEF.md
# Local interrupt priority and acceptance unit

This unit is the priority core of a per-CPU local interrupt controller. It holds one request bit, one in-service bit and one trigger-mode bit for every vector, a software-written task priority (TPR) and a processor priority (PPR) that only hardware updates. Incoming vectors are offered on an accept interface with a trigger mode and a lowest-priority flag. A request that finds its vector already pending is merged into the existing one and reported as coalesced.

The CPU side sees a pending line. It acknowledges to take the highest deliverable vector, which moves from the request set to the in-service set. It signals end-of-interrupt to retire the highest in-service vector. The priority class of a vector is its upper four bits, and a larger class is more urgent. PPR follows the greater of the TPR class and the class of the highest in-service vector. A vector is deliverable only while its class is strictly above the PPR class.

Top module: `lirq_core`

## Requirements
- R1: After reset every request, in-service and trigger bit is 0, TPR and PPR read 0, the arbitration counter is 0 and irq_pending_o is low.
- R2: With sw_en_i high, an accept of a vector whose request bit is clear raises acc_accepted_o in the same cycle and sets that request bit at the next edge.
- R3: An enabled accept of a vector whose request bit is already set raises acc_coalesced_o (acc_accepted_o stays low, so no wake-up), and the request bit stays set.
- R4: Every enabled accept, coalesced or not, writes the vector's trigger bit: 1 for acc_level_i=1 (level), 0 for acc_level_i=0 (edge).
- R5: With sw_en_i low an accept changes no request or trigger bit and raises neither acc_accepted_o nor acc_coalesced_o.
- R6: Every request offered with acc_lowest_i=1 increments arb_cnt_o by one, modulo 2^ARB_W. This happens before the enable check, so it also counts while disabled. The request is otherwise handled as a fixed delivery.
- R7: PPR equals TPR when TPR[7:4] >= H[7:4], and {H[7:4],4'h0} otherwise. H is the highest in-service vector, or 0 when none is in service.
- R8: irq_pending_o is high exactly when a request bit is set and the highest requested vector's class [7:4] is strictly greater than PPR[7:4].
- R9: An acknowledge with a deliverable vector returns it on ack_vec_o in the same cycle. At the next edge the vector's in-service bit is set, its request bit is cleared and PPR is recomputed.
- R10: An acknowledge with no deliverable vector raises ack_none_o, drives ack_vec_o to 0 and leaves all bits unchanged.
- R11: eoi_i clears the highest set in-service bit and PPR is recomputed at the same edge. With no in-service bit set, eoi_i has no effect.
- R12: The read port returns TPR for rd_sel_i=0 and PPR for rd_sel_i=1. Only TPR is written, through tpr_we_i and tpr_wdata_i.
- R13: probe_o returns {request, in-service, trigger} bits (bit 2, bit 1, bit 0) of vector probe_vec_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_en_i | input | 1 | Software enable of the unit |
| acc_valid_i | input | 1 | Accept request strobe |
| acc_vec_i | input | 8 | Vector offered |
| acc_level_i | input | 1 | 1 level-triggered, 0 edge-triggered |
| acc_lowest_i | input | 1 | Lowest-priority delivery |
| acc_accepted_o | output | 1 | Request newly latched (wake-up) |
| acc_coalesced_o | output | 1 | Request merged into a pending one |
| arb_cnt_o | output | ARB_W | Arbitration-priority counter |
| ack_i | input | 1 | Acknowledge strobe |
| ack_vec_o | output | 8 | Vector handed over on acknowledge |
| ack_none_o | output | 1 | No deliverable vector |
| eoi_i | input | 1 | End-of-interrupt strobe |
| irq_pending_o | output | 1 | Deliverable interrupt present |
| tpr_we_i | input | 1 | TPR write enable |
| tpr_wdata_i | input | 8 | TPR write data |
| rd_sel_i | input | 1 | 0 TPR, 1 PPR |
| rd_data_o | output | 8 | Read data |
| probe_vec_i | input | 8 | Vector to inspect |
| probe_o | output | 3 | {request, in-service, trigger} of that vector |

## Verification
On every cycle the assertions check several edge-to-edge relations. An accept latches its request bit and trigger bit. A disabled accept leaves the bits alone. An acknowledge moves its vector and sets the PPR class to the vector's class. An empty acknowledge or an end-of-interrupt does only what it should. PPR never drops below the TPR class, and the lowest-priority counter steps by one. The full PPR formula over all TPR values, the order in which vectors drain, and the pending line compared with the PPR class are shown only by the bench. It accepts all 256 vectors, acknowledges and retires them from the top down, and sweeps every TPR value against a fixed in-service vector.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int unsigned VEC_W_DEF = 8;
  localparam int unsigned CLS_W_DEF = 4;
  localparam int unsigned ARB_W_DEF = 8;

  typedef enum logic {
    RD_TPR = 1'b0,
    RD_PPR = 1'b1
  } rd_sel_e;
endpackage

// File: rtl/lirq_prio_enc.sv
module lirq_prio_enc #(
  parameter int unsigned N  = 256,
  parameter int unsigned IW = 8
) (
  input  logic [N-1:0]  bits_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // highest set bit wins: later iterations overwrite earlier ones
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (bits_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/lirq_ppr_calc.sv
module lirq_ppr_calc #(
  parameter int unsigned VEC_W = 8,
  parameter int unsigned CLS_W = 4
) (
  input  logic [VEC_W-1:0] tpr_i,
  input  logic             isr_found_i,
  input  logic [VEC_W-1:0] isr_top_i,
  output logic [VEC_W-1:0] ppr_o
);
  localparam int unsigned SUB_W = VEC_W - CLS_W;

  logic [VEC_W-1:0] isrv;
  assign isrv = isr_found_i ? isr_top_i : '0;

  always_comb begin
    if (tpr_i[VEC_W-1 -: CLS_W] >= isrv[VEC_W-1 -: CLS_W]) ppr_o = tpr_i;
    else ppr_o = {isrv[VEC_W-1 -: CLS_W], {SUB_W{1'b0}}};
  end
endmodule

// File: rtl/lirq_vec_regs.sv
module lirq_vec_regs #(
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned NUM_VEC = 1 << VEC_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_en_i,
  input  logic [VEC_W-1:0]   acc_vec_i,
  input  logic               acc_level_i,
  input  logic               ack_go_i,
  input  logic [VEC_W-1:0]   ack_vec_i,
  input  logic               eoi_go_i,
  input  logic [VEC_W-1:0]   eoi_vec_i,
  output logic [NUM_VEC-1:0] irr_o,
  output logic [NUM_VEC-1:0] isr_o,
  output logic [NUM_VEC-1:0] isr_nxt_o,
  output logic [NUM_VEC-1:0] tmr_o
);
  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;

  for (genvar g = 0; g < int'(NUM_VEC); g++) begin : g_cell
    logic acc_sel, ack_sel, eoi_sel;
    assign acc_sel  = acc_en_i && (acc_vec_i == VEC_W'(g));
    assign ack_sel  = ack_go_i && (ack_vec_i == VEC_W'(g));
    assign eoi_sel  = eoi_go_i && (eoi_vec_i == VEC_W'(g));
    // a new request on the same edge as its acknowledge stays pending
    assign irr_d[g] = acc_sel ? 1'b1 : (ack_sel ? 1'b0 : irr_q[g]);
    assign isr_d[g] = ack_sel ? 1'b1 : (eoi_sel ? 1'b0 : isr_q[g]);
    assign tmr_d[g] = acc_sel ? acc_level_i : tmr_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q <= '0;
      isr_q <= '0;
      tmr_q <= '0;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      tmr_q <= tmr_d;
    end
  end

  assign irr_o     = irr_q;
  assign isr_o     = isr_q;
  assign isr_nxt_o = isr_d;
  assign tmr_o     = tmr_q;

  p_accept_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i |=> irr_q[$past(acc_vec_i)]);

  p_trig_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i |=> (tmr_q[$past(acc_vec_i)] == $past(acc_level_i)));

  p_ack_move_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_go_i && !(acc_en_i && acc_vec_i == ack_vec_i)) |=>
      (isr_q[$past(ack_vec_i)] && !irr_q[$past(ack_vec_i)]));

  p_eoi_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_go_i && !(ack_go_i && ack_vec_i == eoi_vec_i)) |=> !isr_q[$past(eoi_vec_i)]);
endmodule

// File: rtl/lirq_core.sv
module lirq_core
  import lirq_pkg::*;
#(
  parameter int unsigned VEC_W = VEC_W_DEF,
  parameter int unsigned CLS_W = CLS_W_DEF,
  parameter int unsigned ARB_W = ARB_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_en_i,
  input  logic             acc_valid_i,
  input  logic [VEC_W-1:0] acc_vec_i,
  input  logic             acc_level_i,
  input  logic             acc_lowest_i,
  output logic             acc_accepted_o,
  output logic             acc_coalesced_o,
  output logic [ARB_W-1:0] arb_cnt_o,
  input  logic             ack_i,
  output logic [VEC_W-1:0] ack_vec_o,
  output logic             ack_none_o,
  input  logic             eoi_i,
  output logic             irq_pending_o,
  input  logic             tpr_we_i,
  input  logic [VEC_W-1:0] tpr_wdata_i,
  input  logic             rd_sel_i,
  output logic [VEC_W-1:0] rd_data_o,
  input  logic [VEC_W-1:0] probe_vec_i,
  output logic [2:0]       probe_o
);
  localparam int unsigned NUM_VEC = 1 << VEC_W;
  localparam int unsigned TOP     = VEC_W - 1;

  logic [NUM_VEC-1:0] irr, isr, isr_nxt, tmr;
  logic [VEC_W-1:0]   tpr_q, tpr_d, ppr_q, ppr_d;
  logic [ARB_W-1:0]   arb_q;
  logic               acc_en, acc_hit;
  logic               irr_found, isr_found, nxt_found;
  logic [VEC_W-1:0]   irr_top, isr_top, nxt_top;
  logic               deliverable, ack_go, eoi_go;
  rd_sel_e            rd_sel;

  assign acc_en          = acc_valid_i && sw_en_i;
  assign acc_hit         = irr[acc_vec_i];
  assign acc_accepted_o  = acc_en && !acc_hit;
  assign acc_coalesced_o = acc_en && acc_hit;

  lirq_prio_enc #(.N(NUM_VEC), .IW(VEC_W)) i_irr_enc (
    .bits_i(irr), .found_o(irr_found), .idx_o(irr_top));
  lirq_prio_enc #(.N(NUM_VEC), .IW(VEC_W)) i_isr_enc (
    .bits_i(isr), .found_o(isr_found), .idx_o(isr_top));
  lirq_prio_enc #(.N(NUM_VEC), .IW(VEC_W)) i_nxt_enc (
    .bits_i(isr_nxt), .found_o(nxt_found), .idx_o(nxt_top));

  assign deliverable   = irr_found && (irr_top[TOP -: CLS_W] > ppr_q[TOP -: CLS_W]);
  assign irq_pending_o = deliverable;
  assign ack_go        = ack_i && deliverable;
  assign ack_vec_o     = deliverable ? irr_top : '0;
  assign ack_none_o    = !deliverable;
  assign eoi_go        = eoi_i && isr_found;

  lirq_vec_regs #(.VEC_W(VEC_W), .NUM_VEC(NUM_VEC)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_en_i   (acc_en),
    .acc_vec_i  (acc_vec_i),
    .acc_level_i(acc_level_i),
    .ack_go_i   (ack_go),
    .ack_vec_i  (irr_top),
    .eoi_go_i   (eoi_go),
    .eoi_vec_i  (isr_top),
    .irr_o      (irr),
    .isr_o      (isr),
    .isr_nxt_o  (isr_nxt),
    .tmr_o      (tmr)
  );

  assign tpr_d = tpr_we_i ? tpr_wdata_i : tpr_q;

  // PPR built from next-state TPR/ISR so it is never a cycle stale
  lirq_ppr_calc #(.VEC_W(VEC_W), .CLS_W(CLS_W)) i_ppr (
    .tpr_i(tpr_d), .isr_found_i(nxt_found), .isr_top_i(nxt_top), .ppr_o(ppr_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tpr_q <= '0;
      ppr_q <= '0;
      arb_q <= '0;
    end else begin
      tpr_q <= tpr_d;
      ppr_q <= ppr_d;
      if (acc_valid_i && acc_lowest_i) arb_q <= arb_q + 1'b1;
    end
  end

  assign arb_cnt_o = arb_q;
  assign rd_sel    = rd_sel_e'(rd_sel_i);
  assign rd_data_o = (rd_sel == RD_PPR) ? ppr_q : tpr_q;
  assign probe_o   = {irr[probe_vec_i], isr[probe_vec_i], tmr[probe_vec_i]};

  p_ppr_floor_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppr_q[TOP -: CLS_W] >= tpr_q[TOP -: CLS_W]);

  p_ppr_sub_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ppr_q[TOP-CLS_W:0] == tpr_q[TOP-CLS_W:0]) || (ppr_q[TOP-CLS_W:0] == '0));

  p_arb_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_lowest_i) |=> (arb_q == $past(arb_q) + 1'b1));

  p_disabled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !sw_en_i && !ack_go && !eoi_go) |=> ($stable(irr) && $stable(tmr)));

  p_none_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_none_o && !eoi_i) |=> $stable(isr));

  p_ack_ppr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_go && !tpr_we_i) |=> (ppr_q[TOP -: CLS_W] == $past(irr_top[TOP -: CLS_W])));
endmodule

// File: tb/test_lirq_core.sv
module test_lirq_core;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sw_en_i = 1'b0, acc_valid_i = 1'b0, acc_level_i = 1'b0, acc_lowest_i = 1'b0;
  logic [7:0] acc_vec_i = '0;
  logic       acc_accepted_o, acc_coalesced_o;
  logic [7:0] arb_cnt_o;
  logic       ack_i = 1'b0, ack_none_o, eoi_i = 1'b0, irq_pending_o;
  logic [7:0] ack_vec_o;
  logic       tpr_we_i = 1'b0, rd_sel_i = 1'b0;
  logic [7:0] tpr_wdata_i = '0, rd_data_o, probe_vec_i = '0;
  logic [2:0] probe_o;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lirq_core i_lirq_core (
    .clk_i(clk), .rst_ni(rst_ni), .sw_en_i(sw_en_i), .acc_valid_i(acc_valid_i),
    .acc_vec_i(acc_vec_i), .acc_level_i(acc_level_i), .acc_lowest_i(acc_lowest_i),
    .acc_accepted_o(acc_accepted_o), .acc_coalesced_o(acc_coalesced_o),
    .arb_cnt_o(arb_cnt_o), .ack_i(ack_i), .ack_vec_o(ack_vec_o), .ack_none_o(ack_none_o),
    .eoi_i(eoi_i), .irq_pending_o(irq_pending_o), .tpr_we_i(tpr_we_i),
    .tpr_wdata_i(tpr_wdata_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
    .probe_vec_i(probe_vec_i), .probe_o(probe_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic probe(input string req, input int v, input logic [2:0] exp);
    probe_vec_i = 8'(v);
    #1 chk(req, 32'(probe_o), 32'(exp));
  endtask

  task automatic rd(input string req, input logic sel, input int exp);
    rd_sel_i = sel;
    #1 chk(req, 32'(rd_data_o), 32'(exp));
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd("R1 tpr", 1'b0, 0);
    rd("R1 ppr", 1'b1, 0);
    chk("R1 pending", 32'(irq_pending_o), 0);
    chk("R1 arb", 32'(arb_cnt_o), 0);
    for (int v = 0; v < 256; v++) probe("R1 bits", v, 3'b000);

    // R5 disabled accept
    acc_valid_i = 1'b1; acc_vec_i = 8'h40; acc_level_i = 1'b1;
    #1 chk("R5 accepted", 32'(acc_accepted_o), 0);
    chk("R5 coalesced", 32'(acc_coalesced_o), 0);
    tick();
    acc_valid_i = 1'b0;
    probe("R5 bits", 8'h40, 3'b000);

    // R2/R4/R13 accept every vector, trigger = v[0]
    sw_en_i = 1'b1;
    for (int v = 0; v < 256; v++) begin
      acc_valid_i = 1'b1; acc_vec_i = 8'(v); acc_level_i = v[0];
      #1 chk("R2 accepted", 32'(acc_accepted_o), 1);
      chk("R2 coalesced", 32'(acc_coalesced_o), 0);
      tick();
      acc_valid_i = 1'b0;
      probe("R4 R13 bits", v, {1'b1, 1'b0, v[0]});
    end
    #1 chk("R8 pending all", 32'(irq_pending_o), 1);

    // R3/R4 coalesce with edge on a level vector
    acc_valid_i = 1'b1; acc_vec_i = 8'h81; acc_level_i = 1'b0;
    #1 chk("R3 coalesced", 32'(acc_coalesced_o), 1);
    chk("R3 no wake", 32'(acc_accepted_o), 0);
    tick();
    acc_valid_i = 1'b0;
    probe("R4 tmr cleared", 8'h81, 3'b100);

    // R6 lowest-priority counter, including one disabled request
    acc_lowest_i = 1'b1; acc_vec_i = 8'h10; acc_level_i = 1'b0; acc_valid_i = 1'b1;
    tick(); tick(); tick();
    sw_en_i = 1'b0;
    tick();
    acc_valid_i = 1'b0; acc_lowest_i = 1'b0; sw_en_i = 1'b1;
    #1 chk("R6 arb", 32'(arb_cnt_o), 4);

    // R9/R10/R11/R7 drain from the top with TPR = 0
    for (int v = 255; v >= 16; v--) begin
      logic tb;
      tb = (v == 8'h81) ? 1'b0 : v[0];
      ack_i = 1'b1;
      #1 chk("R9 ack none", 32'(ack_none_o), 0);
      chk("R9 ack vec", 32'(ack_vec_o), 32'(v));
      tick();
      ack_i = 1'b0;
      rd("R7 R9 ppr after ack", 1'b1, v & 8'hF0);
      probe("R9 moved", v, {1'b0, 1'b1, tb});
      chk("R8 blocked by ppr", 32'(irq_pending_o), 0);
      eoi_i = 1'b1;
      tick();
      eoi_i = 1'b0;
      rd("R11 ppr after eoi", 1'b1, 0);
      probe("R11 retired", v, {1'b0, 1'b0, tb});
    end
    ack_i = 1'b1;
    #1 chk("R10 none", 32'(ack_none_o), 1);
    chk("R10 vec zero", 32'(ack_vec_o), 0);
    tick();
    ack_i = 1'b0;
    probe("R10 unchanged", 5, 3'b101);
    chk("R8 class zero", 32'(irq_pending_o), 0);

    // R7/R8/R12 TPR sweep against ISR {0x75} and pending 0x95
    acc_valid_i = 1'b1; acc_vec_i = 8'h75; acc_level_i = 1'b0;
    tick();
    acc_valid_i = 1'b0;
    ack_i = 1'b1;
    #1 chk("R9 ack 75", 32'(ack_vec_o), 32'h75);
    tick();
    ack_i = 1'b0;
    acc_valid_i = 1'b1; acc_vec_i = 8'h95;
    tick();
    acc_valid_i = 1'b0;
    for (int t = 0; t < 256; t++) begin
      int ep;
      ep = ((t >> 4) >= 7) ? t : 8'h70;
      tpr_we_i = 1'b1; tpr_wdata_i = 8'(t);
      tick();
      tpr_we_i = 1'b0;
      rd("R12 tpr", 1'b0, t);
      rd("R7 ppr", 1'b1, ep);
      chk("R8 pending", 32'(irq_pending_o), (9 > (ep >> 4)) ? 1 : 0);
    end

    // R11 eoi then eoi on empty
    tpr_we_i = 1'b1; tpr_wdata_i = 8'h33;
    tick();
    tpr_we_i = 1'b0;
    rd("R7 ppr isr class", 1'b1, 8'h70);
    eoi_i = 1'b1;
    tick();
    rd("R11 ppr to tpr", 1'b1, 8'h33);
    probe("R11 75 cleared", 8'h75, 3'b000);
    tick();
    eoi_i = 1'b0;
    rd("R11 empty eoi", 1'b1, 8'h33);
    probe("R11 95 kept", 8'h95, 3'b100);
    chk("R8 pending 95", 32'(irq_pending_o), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule